// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the exception entry steps for a 16/32-bit processor core with separate user and supervisor stack pointers. On a start request it captures the exception vector number, the current program counter, the condition flags, the interrupt mask, the supervisor bit and the three stack pointer values. It packs these into a status word and moves the core into supervisor mode, exchanging the stack pointers if the core was in user mode. It then pushes a short frame onto the supervisor stack and reads the handler address from the vector table.

All memory traffic goes through one 16-bit port with a request/acknowledge handshake. Each 32-bit value is moved as two word cycles, the high word at the lower address first. When the second word of the handler address has been read, the block pulses `done` for one cycle. At that point the new program counter, the new A7 and the supervisor bit are valid, and `done` also serves as the request to refill the instruction prefetch.

The same block also handles loading the status word from outside. While idle, a load pulse unpacks the written word into the mode, mask and flag fields. If the supervisor bit changes, the stack pointers are exchanged in the direction of the change.

Top module: `exc_entry_seq`

## Requirements
- R1: `sr_out` places S at bit 13, the mask at bits 10:8, and X, N, Z, V, C at bits 4, 3, 2, 1, 0. Every other bit reads 0. `ccr_in` and `ccr_out` carry the flags as {X,N,Z,V,C} in bits 4 down to 0.
- R2: The status word pushed on the stack is packed from the inputs as they were at start, so its bit 13 holds the mode from before entry.
- R3: On entry from user mode (`s_in`=0), `usp_out` becomes `a7_in` and the stack base becomes `ssp_in`. On entry from supervisor mode the stack base is `a7_in` and `usp_out` becomes `usp_in`. In both cases `ssp_out` becomes `ssp_in`, and `s_out` is 1 after entry.
- R4: With stack base B, the frame is written in this order: PC[31:16] at B-4, then PC[15:0] at B-2, then the packed status word at B-6. After entry `a7_out` equals B-6.
- R5: After the writes, the block reads word addresses V*4 and then V*4+2, where V is the vector number. The two words read form `new_pc` as {first, second}.
- R6: A memory request keeps `mem_addr`, `mem_wdata` and `mem_we` stable until a cycle in which `mem_ack` is high. Each cycle with both `mem_req` and `mem_ack` high completes one transfer.
- R7: `busy` is high from the cycle after an accepted start until the cycle after the last acknowledge. `done` is then high for exactly one cycle, with `busy` low.
- R8: A start request that arrives while `busy` is high has no effect on the transfers or on the results.
- R9: A status load while idle sets `s_out` from bit 13, `mask_out` from bits 10:8 and X, N, Z, V, C from bits 4..0 of `sr_wdata`. All other bits of `sr_wdata` are ignored.
- R10: On a status load where S goes from 1 to 0, `ssp_out` becomes `a7_in` and `a7_out` becomes `usp_in`. Where S goes from 0 to 1, `usp_out` becomes `a7_in` and `a7_out` becomes `ssp_in`. Where S does not change, the three pointers pass through unchanged.
- R11: A status load while `busy` is high is ignored. If start and a status load arrive in the same idle cycle, start takes priority.
- R12: A synchronous reset returns the block to idle with `busy`, `done` and `mem_req` low and all result registers zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin exception entry (accepted only while idle) |
| vec_num | input | VEC_W | Exception vector number |
| cur_pc | input | 32 | Program counter to be stacked |
| ccr_in | input | 5 | Flags {X,N,Z,V,C} |
| mask_in | input | 3 | Current interrupt mask |
| s_in | input | 1 | Current supervisor bit |
| a7_in | input | ADDR_W | Current active stack pointer |
| usp_in | input | ADDR_W | Saved user stack pointer |
| ssp_in | input | ADDR_W | Saved supervisor stack pointer |
| sr_load | input | 1 | Load the status word from `sr_wdata` (idle only) |
| sr_wdata | input | 16 | Status word to load |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse; also the prefetch refill request |
| new_pc | output | 32 | Handler address read from the vector table |
| s_out | output | 1 | Resulting supervisor bit |
| mask_out | output | 3 | Resulting interrupt mask |
| ccr_out | output | 5 | Resulting flags {X,N,Z,V,C} |
| sr_out | output | 16 | Packed status word of the resulting state |
| a7_out | output | ADDR_W | Resulting active stack pointer |
| usp_out | output | ADDR_W | Resulting user stack pointer |
| ssp_out | output | ADDR_W | Resulting supervisor stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Acknowledge: the transfer completes in this cycle |

## Verification
The bench uses the default parameters: an 8-bit vector number and a 32-bit address. With these values every one of the 256 vectors can be exercised, and the bench runs an entry for each. The entries alternate between user and supervisor mode and vary the flags and mask, and the bench also inserts 0 to 2 wait cycles before each acknowledge. A second sweep covers every combination of the meaningful status word bits against both old modes, with the don't-care bits both clear and set. This tests the pointer exchange in all four directions of the mode change.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int WORD_W   = 16;
    localparam int PC_W     = 2 * WORD_W;
    localparam int SR_S_BIT = 13;
    localparam int SR_M_LSB = 8;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic       s;
        logic [2:0] mask;
        ccr_t       f;
    } sr_fields_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PC_HI,
        ST_PC_LO,
        ST_SR,
        ST_VEC_HI,
        ST_VEC_LO
    } exc_state_e;

    function automatic logic [WORD_W-1:0] sr_pack(input logic s, input logic [2:0] mask, input ccr_t f);
        logic [WORD_W-1:0] r;
        r = '0;
        r[SR_S_BIT] = s;
        r[SR_M_LSB +: 3] = mask;
        r[4:0] = f;
        return r;
    endfunction

    function automatic sr_fields_t sr_unpack(input logic [WORD_W-1:0] w);
        sr_fields_t r;
        r.s    = w[SR_S_BIT];
        r.mask = w[SR_M_LSB +: 3];
        r.f    = ccr_t'(w[4:0]);
        return r;
    endfunction

endpackage

// File: rtl/exc_sp_select.sv
module exc_sp_select #(
    parameter int ADDR_W = 32
) (
    input  logic              old_s,
    input  logic              new_s,
    input  logic [ADDR_W-1:0] a7,
    input  logic [ADDR_W-1:0] usp,
    input  logic [ADDR_W-1:0] ssp,
    output logic [ADDR_W-1:0] a7_n,
    output logic [ADDR_W-1:0] usp_n,
    output logic [ADDR_W-1:0] ssp_n
);
    always_comb begin
        a7_n  = a7;
        usp_n = usp;
        ssp_n = ssp;
        if (!old_s && new_s) begin
            usp_n = a7;
            a7_n  = ssp;
        end else if (old_s && !new_s) begin
            ssp_n = a7;
            a7_n  = usp;
        end
    end
endmodule

// File: rtl/exc_port_drive.sv
module exc_port_drive
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8
) (
    input  exc_state_e         state,
    input  logic [ADDR_W-1:0]  a7,
    input  logic [PC_W-1:0]    pc,
    input  logic [WORD_W-1:0]  sr_saved,
    input  logic [VEC_W-1:0]   vec,
    output logic               req,
    output logic               we,
    output logic [ADDR_W-1:0]  addr,
    output logic [WORD_W-1:0]  wdata
);
    localparam int PAD_W = ADDR_W - VEC_W - 2;

    logic [ADDR_W-1:0] vec_base;
    assign vec_base = {{PAD_W{1'b0}}, vec, 2'b00};

    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = '0;
        wdata = '0;
        unique case (state)
            ST_PC_HI: begin
                we    = 1'b1;
                addr  = a7;
                wdata = pc[PC_W-1 -: WORD_W];
            end
            ST_PC_LO: begin
                we    = 1'b1;
                addr  = a7 + ADDR_W'(2);
                wdata = pc[WORD_W-1:0];
            end
            ST_SR: begin
                we    = 1'b1;
                addr  = a7;
                wdata = sr_saved;
            end
            ST_VEC_HI: addr = vec_base;
            ST_VEC_LO: addr = vec_base + ADDR_W'(2);
            default:   req  = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic [31:0]       cur_pc,
    input  logic [4:0]        ccr_in,
    input  logic [2:0]        mask_in,
    input  logic              s_in,
    input  logic [ADDR_W-1:0] a7_in,
    input  logic [ADDR_W-1:0] usp_in,
    input  logic [ADDR_W-1:0] ssp_in,
    input  logic              sr_load,
    input  logic [15:0]       sr_wdata,
    output logic              busy,
    output logic              done,
    output logic [31:0]       new_pc,
    output logic              s_out,
    output logic [2:0]        mask_out,
    output logic [4:0]        ccr_out,
    output logic [15:0]       sr_out,
    output logic [ADDR_W-1:0] a7_out,
    output logic [ADDR_W-1:0] usp_out,
    output logic [ADDR_W-1:0] ssp_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack
);
    exc_state_e         state;
    logic [ADDR_W-1:0]  a7_r, usp_r, ssp_r;
    logic               s_r;
    logic [2:0]         mask_r;
    ccr_t               ccr_r;
    logic [PC_W-1:0]    pc_r, new_pc_r;
    logic [WORD_W-1:0]  sr_saved;
    logic [VEC_W-1:0]   vec_r;
    logic               done_r;

    sr_fields_t         wr_fields;
    logic               sel_new_s;
    logic [ADDR_W-1:0]  a7_n, usp_n, ssp_n;
    logic               xfer;

    assign wr_fields = sr_unpack(sr_wdata);
    // Entry always targets supervisor mode; a load takes the written S.
    assign sel_new_s = start ? 1'b1 : wr_fields.s;
    assign xfer      = mem_req && mem_ack;

    exc_sp_select #(.ADDR_W(ADDR_W)) sp_sel_i (
        .old_s (s_in),
        .new_s (sel_new_s),
        .a7    (a7_in),
        .usp   (usp_in),
        .ssp   (ssp_in),
        .a7_n  (a7_n),
        .usp_n (usp_n),
        .ssp_n (ssp_n)
    );

    exc_port_drive #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) port_i (
        .state    (state),
        .a7       (a7_r),
        .pc       (pc_r),
        .sr_saved (sr_saved),
        .vec      (vec_r),
        .req      (mem_req),
        .we       (mem_we),
        .addr     (mem_addr),
        .wdata    (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            a7_r     <= '0;
            usp_r    <= '0;
            ssp_r    <= '0;
            s_r      <= 1'b0;
            mask_r   <= '0;
            ccr_r    <= '0;
            pc_r     <= '0;
            new_pc_r <= '0;
            sr_saved <= '0;
            vec_r    <= '0;
            done_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        // Pack before S is forced so the frame keeps the old mode.
                        sr_saved <= sr_pack(s_in, mask_in, ccr_t'(ccr_in));
                        pc_r     <= cur_pc;
                        vec_r    <= vec_num;
                        s_r      <= 1'b1;
                        mask_r   <= mask_in;
                        ccr_r    <= ccr_t'(ccr_in);
                        usp_r    <= usp_n;
                        ssp_r    <= ssp_n;
                        a7_r     <= a7_n - ADDR_W'(4);
                        state    <= ST_PC_HI;
                    end else if (sr_load) begin
                        s_r    <= wr_fields.s;
                        mask_r <= wr_fields.mask;
                        ccr_r  <= wr_fields.f;
                        a7_r   <= a7_n;
                        usp_r  <= usp_n;
                        ssp_r  <= ssp_n;
                    end
                end
                ST_PC_HI: if (xfer) state <= ST_PC_LO;
                ST_PC_LO: if (xfer) begin
                    a7_r  <= a7_r - ADDR_W'(2);
                    state <= ST_SR;
                end
                ST_SR: if (xfer) state <= ST_VEC_HI;
                ST_VEC_HI: if (xfer) begin
                    new_pc_r[PC_W-1 -: WORD_W] <= mem_rdata;
                    state <= ST_VEC_LO;
                end
                ST_VEC_LO: if (xfer) begin
                    new_pc_r[WORD_W-1:0] <= mem_rdata;
                    done_r <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_r;
    assign new_pc   = new_pc_r;
    assign s_out    = s_r;
    assign mask_out = mask_r;
    assign ccr_out  = ccr_r;
    assign sr_out   = sr_pack(s_r, mask_r, ccr_r);
    assign a7_out   = a7_r;
    assign usp_out  = usp_r;
    assign ssp_out  = ssp_r;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              s_out,
    input logic [15:0]       sr_out,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       mem_wdata
);
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

    assert_busy_req_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> mem_req);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    assert_super_after_entry_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> s_out);

    assert_vec_range_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> (mem_addr >> (VEC_W + 2)) == '0);

    assert_sr_zero_bits_R1: assert property (@(posedge clk) disable iff (rst)
        (sr_out & 16'hD8E0) == 16'h0000);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        busy && start && !mem_ack |=> $stable(mem_addr));

    assert_reset_idle_R12: assert property (@(posedge clk)
        rst |=> !busy && !done && !mem_req);
endmodule

bind exc_entry_seq exc_entry_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .s_out     (s_out),
    .sr_out    (sr_out),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  vec_num = '0;
    logic [31:0] cur_pc = '0;
    logic [4:0]  ccr_in = '0;
    logic [2:0]  mask_in = '0;
    logic        s_in = 1'b0;
    logic [31:0] a7_in = '0, usp_in = '0, ssp_in = '0;
    logic        sr_load = 1'b0;
    logic [15:0] sr_wdata = '0;
    logic        busy, done, s_out, mem_req, mem_we;
    logic [31:0] new_pc, a7_out, usp_out, ssp_out, mem_addr;
    logic [2:0]  mask_out;
    logic [4:0]  ccr_out;
    logic [15:0] sr_out, mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .vec_num(vec_num), .cur_pc(cur_pc),
        .ccr_in(ccr_in), .mask_in(mask_in), .s_in(s_in), .a7_in(a7_in),
        .usp_in(usp_in), .ssp_in(ssp_in), .sr_load(sr_load), .sr_wdata(sr_wdata),
        .busy(busy), .done(done), .new_pc(new_pc), .s_out(s_out),
        .mask_out(mask_out), .ccr_out(ccr_out), .sr_out(sr_out), .a7_out(a7_out),
        .usp_out(usp_out), .ssp_out(ssp_out), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    // Memory model: read data derived from address, 0..2 wait cycles, transfer log.
    assign mem_rdata = mem_addr[15:0] ^ 16'hC3A5;

    int          log_n = 0;
    int          wcnt = 0;
    int          hold_err = 0;
    logic        hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [31:0] lg_addr [16];
    logic [15:0] lg_data [16];
    logic        lg_we   [16];

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            wcnt      <= 0;
            hold_pend <= 1'b0;
        end else begin
            if (hold_pend && (!mem_req || mem_addr != hold_addr)) hold_err <= hold_err + 1;
            hold_pend <= mem_req && !mem_ack;
            hold_addr <= mem_addr;
            if (mem_req && mem_ack) begin
                lg_addr[log_n % 16] <= mem_addr;
                lg_data[log_n % 16] <= mem_wdata;
                lg_we[log_n % 16]   <= mem_we;
                log_n <= log_n + 1;
            end
            if (mem_ack) mem_ack <= 1'b0;
            else if (mem_req) begin
                if (wcnt == 0) begin
                    mem_ack <= 1'b1;
                    wcnt    <= log_n % 3;
                end else wcnt <= wcnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pack_sr(input logic s, input logic [2:0] m, input logic [4:0] f);
        return (16'(s) << 13) | (16'(m) << 8) | 16'(f);
    endfunction

    task automatic do_entry(input logic [7:0] v, input logic s, input logic [31:0] pc,
                            input logic [31:0] a7, input logic [31:0] usp, input logic [31:0] ssp,
                            input logic [2:0] m, input logic [4:0] f, input bit poke, input bit both);
        int          b;
        int          t;
        logic [31:0] base, va;
        logic [15:0] srx;
        @(negedge clk);
        vec_num = v; cur_pc = pc; s_in = s; a7_in = a7; usp_in = usp; ssp_in = ssp;
        mask_in = m; ccr_in = f; start = 1'b1;
        if (both) begin sr_load = 1'b1; sr_wdata = 16'h0000; end
        b = log_n;
        @(negedge clk);
        start = 1'b0; sr_load = 1'b0;
        check(busy == 1'b1, "R7 busy after start", 32'(busy), 32'd1);
        if (poke) begin
            start = 1'b1; sr_load = 1'b1; sr_wdata = 16'h0000; vec_num = ~v;
            cur_pc = ~pc; s_in = ~s; a7_in = 32'h55; usp_in = 32'h77; ssp_in = 32'h99;
            @(negedge clk);
            start = 1'b0; sr_load = 1'b0;
        end
        t = 0;
        while (!done && t < 100) begin @(negedge clk); t++; end
        check(done == 1'b1 && busy == 1'b0, "R7 done pulse with busy low", {30'd0, busy, done}, 32'd1);
        base = s ? a7 : ssp;
        srx  = pack_sr(s, m, f);
        va   = 32'(v) << 2;
        check(s_out == 1'b1, "R3 supervisor set", 32'(s_out), 32'd1);
        check(usp_out == (s ? usp : a7), "R3 user stack pointer", usp_out, s ? usp : a7);
        check(ssp_out == ssp, "R3 supervisor stack pointer kept", ssp_out, ssp);
        check(a7_out == base - 32'd6, "R4 final A7", a7_out, base - 32'd6);
        check(mask_out == m && ccr_out == f, "R1 mask and flags kept", {mask_out, ccr_out}, {m, f});
        check(sr_out == (srx | 16'h2000), "R1 packed result", sr_out, srx | 16'h2000);
        check(log_n - b == 5, "R4 transfer count", log_n - b, 5);
        check(lg_we[b % 16] && lg_addr[b % 16] == base - 32'd4 && lg_data[b % 16] == pc[31:16],
              "R4 high PC word", lg_addr[b % 16], base - 32'd4);
        check(lg_we[(b+1) % 16] && lg_addr[(b+1) % 16] == base - 32'd2 && lg_data[(b+1) % 16] == pc[15:0],
              "R4 low PC word", lg_addr[(b+1) % 16], base - 32'd2);
        check(lg_we[(b+2) % 16] && lg_addr[(b+2) % 16] == base - 32'd6, "R4 status word address",
              lg_addr[(b+2) % 16], base - 32'd6);
        check(lg_data[(b+2) % 16] == srx, "R2 stacked status holds old mode", lg_data[(b+2) % 16], srx);
        check(!lg_we[(b+3) % 16] && lg_addr[(b+3) % 16] == va && !lg_we[(b+4) % 16]
              && lg_addr[(b+4) % 16] == va + 32'd2, "R5 vector reads", lg_addr[(b+3) % 16], va);
        check(new_pc == {va[15:0] ^ 16'hC3A5, (va[15:0] + 16'd2) ^ 16'hC3A5}, "R5 new PC",
              new_pc, {va[15:0] ^ 16'hC3A5, (va[15:0] + 16'd2) ^ 16'hC3A5});
        if (poke) check(1'b1, "R8 R11 busy requests ignored (covered above)", 0, 0);
        if (both) check(s_out == 1'b1, "R11 start wins over load", 32'(s_out), 32'd1);
        @(negedge clk);
        check(done == 1'b0, "R7 done lasts one cycle", 32'(done), 32'd0);
    endtask

    task automatic do_load(input logic old_s, input logic [8:0] code, input bit junk);
        logic [15:0] w;
        logic        ns;
        logic [31:0] ea7, eusp, essp;
        w  = pack_sr(code[8], code[7:5], code[4:0]) | (junk ? 16'hD8E0 : 16'h0000);
        ns = code[8];
        @(negedge clk);
        s_in = old_s; a7_in = 32'h0000_1000 + 32'(code); usp_in = 32'h2000_0000 + 32'(code);
        ssp_in = 32'h3000_0000 + 32'(code); sr_wdata = w; sr_load = 1'b1;
        @(negedge clk);
        sr_load = 1'b0;
        ea7 = a7_in; eusp = usp_in; essp = ssp_in;
        if (old_s && !ns) begin essp = a7_in; ea7 = usp_in; end
        else if (!old_s && ns) begin eusp = a7_in; ea7 = ssp_in; end
        check(s_out == ns && mask_out == code[7:5] && ccr_out == code[4:0], "R9 unpacked fields",
              {s_out, mask_out, ccr_out}, code);
        check(sr_out == (w & 16'h271F), "R1 status layout", sr_out, w & 16'h271F);
        check(a7_out == ea7 && usp_out == eusp && ssp_out == essp, "R10 pointer exchange",
              a7_out, ea7);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && !mem_req, "R12 reset idle", {29'd0, busy, done, mem_req}, 0);
        check(a7_out == 0 && new_pc == 0 && !s_out, "R12 reset results", a7_out, 0);

        for (int v = 0; v < 256; v++) begin
            do_entry(8'(v), v[0], {8'(v), 8'h11, ~8'(v), 8'h3C},
                     32'h0001_0000 + 32'(v) * 16, 32'h0002_0000 + 32'(v),
                     32'h0004_0000 + 32'(v) * 32, 3'(v >> 1), 5'(v >> 3),
                     (v % 5) == 0, (v % 7) == 3);
        end
        // Stack base wraps below zero.
        do_entry(8'h40, 1'b0, 32'hDEAD_BEEF, 32'h10, 32'h20, 32'h2, 3'd7, 5'h1F, 1'b0, 1'b0);

        for (int os = 0; os < 2; os++)
            for (int c = 0; c < 512; c++)
                do_load(os[0], 9'(c), c[0]);

        // Reset in the middle of a sequence.
        @(negedge clk);
        vec_num = 8'h22; s_in = 1'b0; a7_in = 32'h100; ssp_in = 32'h800; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && !mem_req, "R12 reset mid-sequence", {29'd0, busy, done, mem_req}, 0);
        check(a7_out == 0 && usp_out == 0 && ssp_out == 0, "R12 pointers cleared", a7_out, 0);

        check(hold_err == 0, "R6 request held until acknowledge", hold_err, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule